// File: doc/BRIEF.md
# Dual-Output Programmable Reference Divider

This block divides a reference clock by a programmable ratio and hands out comparison strobes to two phase-locked loops, A and B. Each strobe is one reference cycle wide. The divider output is a square wave. It is high for the first half of each period and low for the rest. Loop A is strobed on the rising edge of that wave and loop B on the falling edge, so the two loops never see their comparison events in the same cycle. A half-rate select can route loop B's strobe through a divide-by-two stage, which gives loop B one event for every two divider periods.

Each loop has its own power enable, where 1 means powered. The divider runs while at least one loop is powered. When both loops are off, the divider stops in a cleared state. Powering either loop up again restarts the divider from count zero with the halving stage cleared. The loops therefore resume from a known phase instead of a random one. A new ratio is latched only at the end of the current period, so no period is ever cut short.

The controller is a three-state machine. ST_OFF means the divider is stopped. ST_HIGH is the high half of the output. ST_LOW is the low half. There are four transitions:
- T_WAKE (ST_OFF to ST_HIGH) fires when either enable is high.
- T_FALL (ST_HIGH to ST_LOW) fires when the count reaches floor(P/2)-1.
- T_WRAP (ST_LOW to ST_HIGH) fires at the terminal count P-1, and the ratio is reloaded there.
- T_SLEEP (ST_HIGH or ST_LOW to ST_OFF) fires when both enables are low.

Top module: `dual_ref_divider`

## Requirements
- R1: While reset is asserted, and after reset while both enables stay low, both strobes stay low.
- R2: While running, strobe_a_o is high in the first cycle of every period (count 0) if pwr_a_i is high, giving one pulse every P cycles.
- R3: The divider output is high for floor(P/2) cycles. The loop B event sits at count floor(P/2), exactly floor(P/2) cycles after the loop A event, and the two strobes are never high in the same cycle.
- R4: With half_b_i = 0 loop B is strobed every P cycles. With half_b_i = 1 it is strobed on every second falling edge (every 2P cycles), starting with the first falling edge after a restart.
- R5: The effective period P equals ratio_i (12 bits, unsigned) when ratio_i >= 8, and equals 8 otherwise.
- R6: A ratio_i change takes effect only at the next terminal count. The period in progress keeps its old length.
- R7: When both enables are low at a clock edge, the divider stops and both strobes are low from the next cycle. When an enable next rises, the first period starts at count 0 in the cycle after the edge that samples it, with the halving stage cleared.
- R8: With only one loop enabled the divider keeps its phase. The disabled loop's strobe stays low and the other loop's strobe keeps its spacing.
- R9: Each strobe is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_i | input | 12 | Programmed division ratio |
| half_b_i | input | 1 | 1 = loop B at half the comparison rate |
| pwr_a_i | input | 1 | Loop A power enable (1 = on) |
| pwr_b_i | input | 1 | Loop B power enable (1 = on) |
| strobe_a_o | output | 1 | Loop A comparison strobe |
| strobe_b_o | output | 1 | Loop B comparison strobe |

## Verification
The ratio reload and the period boundary can fall in the same cycle. So can a loop wake-up and a ratio change. The bench writes a new ratio a few cycles before a terminal count, and it also releases both enables into a fresh ratio, to provoke both cases. The measured strobe spacing then shows which period length was used. A behavioural model in the bench is compared with both strobes on every clock, so any disagreement at these boundaries shows up in the exact cycle where it happens.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } rdiv_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } rdiv_edge_t;

endpackage

// File: rtl/rdiv_core.sv
module rdiv_core
    import rdiv_pkg::*;
#(
    parameter int unsigned W    = 12,
    parameter int unsigned RMIN = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio_i,
    input  logic         run_req_i,
    output rdiv_edge_t   edge_o,
    output logic         idle_o
);

    localparam logic [W-1:0] ONE_W  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] RMIN_W = W'(RMIN);

    rdiv_state_e  state_q, state_d;
    logic [W-1:0] cnt_q;
    logic [W-1:0] per_q;
    logic [W-1:0] per_clamped;
    logic [W-1:0] half_cnt;
    logic         at_fall;
    logic         at_wrap;

    assign per_clamped = (ratio_i < RMIN_W) ? RMIN_W : ratio_i;
    assign half_cnt    = per_q >> 1;
    assign at_fall     = (cnt_q == half_cnt - ONE_W);
    assign at_wrap     = (cnt_q == per_q - ONE_W);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: T_WAKE, T_FALL, T_WRAP, T_SLEEP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (run_req_i) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (!run_req_i)   state_d = ST_OFF;
                else if (at_fall) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (!run_req_i)   state_d = ST_OFF;
                else if (at_wrap) state_d = ST_HIGH;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // count and period latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= RMIN_W;
        end else if (state_q == ST_OFF || !run_req_i) begin
            cnt_q <= '0;
            per_q <= per_clamped;
        end else if (state_q == ST_LOW && at_wrap) begin
            cnt_q <= '0;
            per_q <= per_clamped;
        end else begin
            cnt_q <= cnt_q + ONE_W;
        end
    end

    // outputs
    always_comb begin
        edge_o.rise = (state_q == ST_HIGH) && (cnt_q == '0);
        edge_o.fall = (state_q == ST_LOW)  && (cnt_q == half_cnt);
        idle_o      = (state_q == ST_OFF);
    end

endmodule

// File: rtl/rdiv_bpath.sv
module rdiv_bpath (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_i,
    input  logic fall_i,
    input  logic half_sel_i,
    output logic evt_o
);

    logic skip_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            skip_q <= 1'b0;
        end else if (idle_i) begin
            skip_q <= 1'b0;
        end else if (fall_i) begin
            skip_q <= ~skip_q;
        end
    end

    assign evt_o = fall_i && (!half_sel_i || !skip_q);

endmodule

// File: rtl/dual_ref_divider.sv
module dual_ref_divider
    import rdiv_pkg::*;
#(
    parameter int unsigned W    = 12,
    parameter int unsigned RMIN = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio_i,
    input  logic         half_b_i,
    input  logic         pwr_a_i,
    input  logic         pwr_b_i,
    output logic         strobe_a_o,
    output logic         strobe_b_o
);

    rdiv_edge_t edges;
    logic       idle;
    logic       b_evt;

    rdiv_core #(.W(W), .RMIN(RMIN)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_i   (ratio_i),
        .run_req_i (pwr_a_i | pwr_b_i),
        .edge_o    (edges),
        .idle_o    (idle)
    );

    rdiv_bpath u_bpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_i     (idle),
        .fall_i     (edges.fall),
        .half_sel_i (half_b_i),
        .evt_o      (b_evt)
    );

    assign strobe_a_o = edges.rise && pwr_a_i;
    assign strobe_b_o = b_evt && pwr_b_i;

endmodule

// File: rtl/dual_ref_divider_chk.sv
module dual_ref_divider_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_a_i,
    input logic pwr_b_i,
    input logic strobe_a_o,
    input logic strobe_b_o
);

    // R3: loop strobes never coincide
    p_no_coincide_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_a_o && strobe_b_o));

    // R9: single-cycle pulses
    p_pulse_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_a_o |=> !strobe_a_o);

    p_pulse_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_b_o |=> !strobe_b_o);

    // R7: quiet after both loops go down
    p_quiet_after_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_a_i && !pwr_b_i) |=> (!strobe_a_o && !strobe_b_o));

    // R7: wake restarts at count zero with a loop A event
    p_wake_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_a_i && !pwr_b_i) ##1 pwr_a_i ##1 pwr_a_i |-> strobe_a_o);

endmodule

bind dual_ref_divider dual_ref_divider_chk u_chk (.*);

// File: tb/sim_dual_ref_divider.sv
module sim_dual_ref_divider;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ratio = 12'd20;
    logic        half_b = 1'b0;
    logic        pwr_a = 1'b0;
    logic        pwr_b = 1'b0;
    logic        strobe_a, strobe_b;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // behavioural model
    bit m_run = 0;
    int m_cnt = 0;
    int m_per = 8;
    bit m_tg  = 0;

    always #(CLK_P/2) clk = ~clk;

    dual_ref_divider u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_i    (ratio),
        .half_b_i   (half_b),
        .pwr_a_i    (pwr_a),
        .pwr_b_i    (pwr_b),
        .strobe_a_o (strobe_a),
        .strobe_b_o (strobe_b)
    );

    function automatic int eff(input int r);
        return (r < 8) ? 8 : r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_run = 0;
        end else if (!pwr_a && !pwr_b) begin
            m_run = 0;
        end else if (!m_run) begin
            m_run = 1; m_cnt = 0; m_per = eff(ratio); m_tg = 0;
        end else begin
            if (m_cnt == m_per / 2) m_tg = ~m_tg;
            if (m_cnt == m_per - 1) begin
                m_cnt = 0; m_per = eff(ratio);
            end else begin
                m_cnt++;
            end
        end
    end

    always @(negedge clk) begin
        bit ea, eb;
        if (!rst_n) begin
            chk(!strobe_a && !strobe_b, "R1 reset strobes", {strobe_a, strobe_b}, 0);
        end else begin
            ea = m_run && m_cnt == 0 && pwr_a;
            eb = m_run && m_cnt == m_per / 2 && pwr_b && (!half_b || !m_tg);
            chk(strobe_a == ea, "R2 strobe_a model", strobe_a, ea);
            chk(strobe_b == eb, "R4 strobe_b model", strobe_b, eb);
        end
    end

    task automatic wait_a(output int t);
        do @(negedge clk); while (!strobe_a);
        t = cyc;
    endtask

    task automatic wait_b(output int t);
        do @(negedge clk); while (!strobe_b);
        t = cyc;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        int t0, t1, t2, tb0, tb1, c0, na;
        #(CLK_P * 150000);
        fails++;
        $display("FAIL R2 watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int t0, t1, t2, tb0, tb1, c0, na;
        step(4);
        rst_n = 1'b1;
        step(10);
        // R1: idle with no enable, model checks quiet outputs

        // R5: clamp of small ratio
        ratio = 12'd3; pwr_a = 1; pwr_b = 1;
        wait_a(t0); wait_a(t1);
        chk(t1 - t0 == 8, "R5 clamped period", t1 - t0, 8);

        // R2, R3, R4: even ratio, full rate
        ratio = 12'd20;
        wait_a(t0); wait_a(t0); wait_b(tb0); wait_a(t1); wait_b(tb1);
        chk(t1 - t0 == 20, "R2 period A", t1 - t0, 20);
        chk(tb0 - t0 == 10, "R3 B offset even", tb0 - t0, 10);
        chk(tb1 - tb0 == 20, "R4 period B full rate", tb1 - tb0, 20);

        // R3: odd ratio offset
        ratio = 12'd13;
        wait_a(t0); wait_a(t0); wait_b(tb0);
        chk(tb0 - t0 == 6, "R3 B offset odd", tb0 - t0, 6);

        // R4: half rate on B
        ratio = 12'd20; half_b = 1;
        wait_a(t0); wait_a(t0);
        wait_b(tb0); wait_b(tb1);
        chk(tb1 - tb0 == 40, "R4 period B half rate", tb1 - tb0, 40);

        // R6: reload only at terminal count
        half_b = 0;
        wait_a(t0);
        step(1);
        ratio = 12'd30;
        wait_a(t1); wait_a(t2);
        chk(t1 - t0 == 20, "R6 current period kept", t1 - t0, 20);
        chk(t2 - t1 == 30, "R6 new period used", t2 - t1, 30);

        // R8: loop A off, B keeps its spacing
        pwr_a = 0;
        na = 0;
        wait_b(tb0);
        c0 = cyc;
        do begin @(negedge clk); if (strobe_a) na++; end while (!strobe_b);
        chk(cyc - c0 == 30, "R8 B spacing with A off", cyc - c0, 30);
        chk(na == 0, "R8 A silent when off", na, 0);

        // R7: both off, then wake with new ratio and half rate
        step(3);
        pwr_b = 0;
        step(6);
        ratio = 12'd16; half_b = 1; pwr_a = 1; pwr_b = 1;
        c0 = cyc;
        wait_a(t0);
        chk(t0 == c0 + 1, "R7 wake timing", t0 - c0, 1);
        wait_b(tb0);
        chk(tb0 - t0 == 8, "R7 toggle cleared on wake", tb0 - t0, 8);
        wait_b(tb1);
        chk(tb1 - tb0 == 32, "R7 half rate after wake", tb1 - tb0, 32);

        // R9: pulse width
        wait_a(t0);
        @(negedge clk);
        chk(!strobe_a, "R9 single-cycle A", strobe_a, 0);

        step(50);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule